// File: doc/BRIEF.md
# High-Speed Paper-Tape Reader and Punch Sequencer

This block sequences a parallel high-speed tape reader and a high-speed tape punch. Software sets a drive bit to step the reader one frame. When the reader raises its data-available line, the drive is dropped and a settling timer runs. The data-ready flag is raised only after the delay, and only when the reader reports that it is in run mode and powered. The timer also caps how often the processor can pull characters from the reader.

For the punch, a data write latches one byte. When the write strobe ends, a punch command pulse of fixed width starts. The punch error flag combines the mechanism's fault lines. The punch is reported ready when no pulse is in flight and no fault is present.

The address decode that produces the write and read strobes sits outside this block. Both delays are given in microseconds and converted to clock cycles from a clock-frequency parameter. The tape mechanics are modelled as plain handshake inputs, assumed synchronous to `clk`.

Top module: `tape_sequencer`

## Requirements
- R1: After reset, rdrDrive, rdrReady, rdrError, punchCmd, punchByte and punError are all 0, and punReady is 1.
- R2: A cycle with rdrCtlWr high and wrData bit 2 set makes rdrDrive 1 after that clock edge. A control write with bit 2 clear leaves rdrDrive unchanged.
- R3: A rising edge on rdrDav, seen while no settling delay is running, clears rdrDrive at the edge that captures it. This takes priority over a simultaneous drive write.
- R4: The edge that captures an rdrDav rise starts a delay of SETTLE_CYC = CLK_HZ/1000*SETTLE_US/1000 cycles. rdrReady becomes 1 exactly SETTLE_CYC edges later, and only if rdrRun and rdrPower are both 1 at the end of the delay.
- R5: If rdrRun or rdrPower is 0 when an rdrDav rise is captured, rdrError becomes 1 at that edge, and no ready follows unless both lines are 1 at the end of the delay.
- R6: An rdrDav rise that arrives while a settling delay is running is ignored. It does not clear rdrDrive, and it does not restart or shift the delay.
- R7: A cycle with rdrDataRd high clears rdrReady and rdrError at that edge. A ready set in the same cycle wins.
- R8: While punWr is high, punchByte takes wrData at each edge. Writes made while punchCmd is 1 are ignored, and the latched byte is kept.
- R9: The first edge after an accepted punch write ends raises punchCmd. punchCmd stays 1 for exactly PULSE_CYC = CLK_HZ/1000*PULSE_US/1000 cycles.
- R10: punError equals punTapeErr OR punTapeLow OR NOT punSysReady, registered one cycle.
- R11: punReady is 1 exactly when punchCmd is 0 and punError is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| rdrCtlWr | input | 1 | Write strobe for the reader control register |
| rdrDataRd | input | 1 | Read strobe for the reader data register |
| punWr | input | 1 | Write strobe for the punch data register |
| wrData | input | 8 | Write data bus |
| rdrDav | input | 1 | Reader data-available line |
| rdrRun | input | 1 | Reader in run mode |
| rdrPower | input | 1 | Reader powered |
| punTapeErr | input | 1 | Punch tape or chad fault |
| punTapeLow | input | 1 | Punch tape supply low |
| punSysReady | input | 1 | Punch system ready |
| rdrDrive | output | 1 | Reader step drive |
| rdrReady | output | 1 | Reader data ready |
| rdrError | output | 1 | Reader error |
| punchByte | output | 8 | Latched punch byte |
| punchCmd | output | 1 | Punch command pulse |
| punError | output | 1 | Punch error summary |
| punReady | output | 1 | Punch ready |

## Verification
The bench measures the settling delay to the exact edge. A timer that is off by one would raise ready a cycle early or late, and the check one cycle either side of the edge would catch it. A second data-available rise is injected mid-delay while the drive is set again. A design that restarts the timer or re-clears the drive would fail here. Run or power is dropped partway through a delay to prove that ready is judged at the end of the delay. Punch writes made during a pulse must neither change the byte nor stretch or retrigger the pulse.

// File: rtl/tape_pkg.sv
package tape_pkg;

  // Strobes issued by the control section to the datapath
  typedef struct packed {
    logic setDrive;   // raise reader drive
    logic clrDrive;   // drop reader drive
    logic setReady;   // raise reader ready
    logic setError;   // raise reader error
    logic clrFlags;   // data register read: clear ready and error
    logic loadByte;   // capture punch byte
  } tapeStrobes_t;

  localparam int DRIVE_BIT = 2;

endpackage

// File: rtl/tape_ctrl.sv
module tape_ctrl
  import tape_pkg::*;
#(
  parameter int SETTLE_CYC = 1500,
  parameter int PULSE_CYC  = 10
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         ctlWr,
  input  logic         driveBit,
  input  logic         dataRd,
  input  logic         dav,
  input  logic         sysOk,
  input  logic         punWr,
  output tapeStrobes_t strobes,
  output logic         punchCmd
);

  localparam int SW = $clog2(SETTLE_CYC + 1);
  localparam int PW = $clog2(PULSE_CYC + 1);

  logic          davPrev;
  logic          wrTaken;
  logic          davRise;
  logic          wrEnd;
  logic          settleBusy;
  logic [SW-1:0] settleCnt;
  logic          settleDone;
  logic          pulseOn;
  logic [PW-1:0] pulseCnt;

  assign davRise    = dav & ~davPrev;
  assign wrEnd      = wrTaken & ~punWr;
  assign settleDone = settleBusy && (settleCnt == '0);

  always_comb begin
    strobes          = '0;
    strobes.setDrive = ctlWr & driveBit;
    strobes.clrDrive = davRise & ~settleBusy;
    strobes.setError = davRise & ~settleBusy & ~sysOk;
    strobes.setReady = settleDone & sysOk;
    strobes.clrFlags = dataRd;
    strobes.loadByte = punWr & ~pulseOn;
  end

  // Edge history
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      davPrev <= 1'b0;
      wrTaken <= 1'b0;
    end else begin
      davPrev <= dav;
      wrTaken <= strobes.loadByte;
    end
  end

  // Reader settling timer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      settleBusy <= 1'b0;
      settleCnt  <= '0;
    end else if (settleBusy) begin
      if (settleCnt == '0) settleBusy <= 1'b0;
      else                 settleCnt  <= settleCnt - 1'b1;
    end else if (davRise) begin
      settleBusy <= 1'b1;
      settleCnt  <= SW'(SETTLE_CYC - 1);
    end
  end

  // Punch command one-shot
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pulseOn  <= 1'b0;
      pulseCnt <= '0;
    end else if (pulseOn) begin
      if (pulseCnt == '0) pulseOn  <= 1'b0;
      else                pulseCnt <= pulseCnt - 1'b1;
    end else if (wrEnd) begin
      pulseOn  <= 1'b1;
      pulseCnt <= PW'(PULSE_CYC - 1);
    end
  end

  assign punchCmd = pulseOn;

  // Independent age counters for the checks below
  int settleAge;
  int pulseAge;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      settleAge <= 0;
      pulseAge  <= 0;
    end else begin
      settleAge <= settleBusy ? settleAge + 1 : 0;
      pulseAge  <= pulseOn ? pulseAge + 1 : 0;
    end
  end

  AST_SETTLE_WINDOW: assert property (@(posedge clk) disable iff (!rstN)
    settleAge <= SETTLE_CYC); // R4
  AST_PULSE_WIDTH: assert property (@(posedge clk) disable iff (!rstN)
    pulseAge <= PULSE_CYC); // R9
  AST_PULSE_FULL: assert property (@(posedge clk) disable iff (!rstN)
    $fell(pulseOn) |-> $past(pulseAge) == PULSE_CYC - 1); // R9

endmodule

// File: rtl/tape_datapath.sv
module tape_datapath
  import tape_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  tapeStrobes_t strobes,
  input  logic [7:0]   wrData,
  input  logic         punchCmd,
  input  logic         punTapeErr,
  input  logic         punTapeLow,
  input  logic         punSysReady,
  output logic         rdrDrive,
  output logic         rdrReady,
  output logic         rdrError,
  output logic [7:0]   punchByte,
  output logic         punError,
  output logic         punReady
);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdrDrive <= 1'b0;
    end else if (strobes.clrDrive) begin
      rdrDrive <= 1'b0;
    end else if (strobes.setDrive) begin
      rdrDrive <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdrReady <= 1'b0;
      rdrError <= 1'b0;
    end else begin
      if (strobes.setReady)      rdrReady <= 1'b1;
      else if (strobes.clrFlags) rdrReady <= 1'b0;
      if (strobes.setError)      rdrError <= 1'b1;
      else if (strobes.clrFlags) rdrError <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      punchByte <= '0;
      punError  <= 1'b0;
    end else begin
      if (strobes.loadByte) punchByte <= wrData;
      punError <= punTapeErr | punTapeLow | ~punSysReady;
    end
  end

  assign punReady = ~punchCmd & ~punError;

  AST_DRIVE_DROP: assert property (@(posedge clk) disable iff (!rstN)
    strobes.clrDrive |=> !rdrDrive); // R3
  AST_BYTE_HELD: assert property (@(posedge clk) disable iff (!rstN)
    punchCmd |=> $stable(punchByte)); // R8
  AST_READY_STICKS: assert property (@(posedge clk) disable iff (!rstN)
    (rdrReady && !strobes.clrFlags) |=> rdrReady); // R7

endmodule

// File: rtl/tape_sequencer.sv
module tape_sequencer
  import tape_pkg::*;
#(
  parameter int CLK_HZ    = 1_000_000,
  parameter int SETTLE_US = 1500,
  parameter int PULSE_US  = 10
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       rdrCtlWr,
  input  logic       rdrDataRd,
  input  logic       punWr,
  input  logic [7:0] wrData,
  input  logic       rdrDav,
  input  logic       rdrRun,
  input  logic       rdrPower,
  input  logic       punTapeErr,
  input  logic       punTapeLow,
  input  logic       punSysReady,
  output logic       rdrDrive,
  output logic       rdrReady,
  output logic       rdrError,
  output logic [7:0] punchByte,
  output logic       punchCmd,
  output logic       punError,
  output logic       punReady
);

  localparam int CLK_KHZ    = CLK_HZ / 1000;
  localparam int SETTLE_CYC = CLK_KHZ * SETTLE_US / 1000;
  localparam int PULSE_CYC  = CLK_KHZ * PULSE_US / 1000;

  tapeStrobes_t strobes;
  logic         sysOk;

  assign sysOk = rdrRun & rdrPower;

  tape_ctrl #(
    .SETTLE_CYC(SETTLE_CYC),
    .PULSE_CYC (PULSE_CYC)
  ) uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .ctlWr   (rdrCtlWr),
    .driveBit(wrData[DRIVE_BIT]),
    .dataRd  (rdrDataRd),
    .dav     (rdrDav),
    .sysOk   (sysOk),
    .punWr   (punWr),
    .strobes (strobes),
    .punchCmd(punchCmd)
  );

  tape_datapath uData (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .wrData     (wrData),
    .punchCmd   (punchCmd),
    .punTapeErr (punTapeErr),
    .punTapeLow (punTapeLow),
    .punSysReady(punSysReady),
    .rdrDrive   (rdrDrive),
    .rdrReady   (rdrReady),
    .rdrError   (rdrError),
    .punchByte  (punchByte),
    .punError   (punError),
    .punReady   (punReady)
  );

  AST_READY_NEEDS_SYS: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rdrReady) |-> $past(rdrRun && rdrPower)); // R4

endmodule

// File: tb/sim_tape_sequencer.sv
module sim_tape_sequencer;

  localparam int PERIOD = 10;
  localparam int SETTLE = 1500;  // 1.5 ms at 1 MHz
  localparam int PULSE  = 10;    // 10 us at 1 MHz

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       rdrCtlWr = 0, rdrDataRd = 0, punWr = 0;
  logic [7:0] wrData = '0;
  logic       rdrDav = 0, rdrRun = 1, rdrPower = 1;
  logic       punTapeErr = 0, punTapeLow = 0, punSysReady = 1;
  logic       rdrDrive, rdrReady, rdrError, punchCmd, punError, punReady;
  logic [7:0] punchByte;

  always #(PERIOD/2) clk = ~clk;

  tape_sequencer u0 (
    .clk(clk), .rstN(rstN), .rdrCtlWr(rdrCtlWr), .rdrDataRd(rdrDataRd),
    .punWr(punWr), .wrData(wrData), .rdrDav(rdrDav), .rdrRun(rdrRun),
    .rdrPower(rdrPower), .punTapeErr(punTapeErr), .punTapeLow(punTapeLow),
    .punSysReady(punSysReady), .rdrDrive(rdrDrive), .rdrReady(rdrReady),
    .rdrError(rdrError), .punchByte(punchByte), .punchCmd(punchCmd),
    .punError(punError), .punReady(punReady)
  );

  typedef struct {
    string tag;
    int    sel;
    int    exp;
  } item_t;

  item_t expQ[$];
  int checks = 0;
  int errors = 0;
  bit done   = 0;

  localparam int S_DRIVE = 0, S_READY = 1, S_ERROR = 2, S_CMD = 3,
                 S_BYTE = 4, S_PERR = 5, S_PRDY = 6;

  function automatic int outVal(int sel);
    case (sel)
      S_DRIVE: return int'(rdrDrive);
      S_READY: return int'(rdrReady);
      S_ERROR: return int'(rdrError);
      S_CMD:   return int'(punchCmd);
      S_BYTE:  return int'(punchByte);
      S_PERR:  return int'(punError);
      default: return int'(punReady);
    endcase
  endfunction

  task automatic expectOut(string tag, int sel, int exp);
    item_t it;
    it.tag = tag; it.sel = sel; it.exp = exp;
    expQ.push_back(it);
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  // Monitor: compares queued expectations just after each falling edge
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (expQ.size() > 0) begin
        item_t it;
        int    act;
        it  = expQ.pop_front();
        act = outVal(it.sel);
        checks++;
        if (act !== it.exp) begin
          errors++;
          $display("FAIL %s: actual %0d expected %0d", it.tag, act, it.exp);
        end
      end
    end
  end

  task automatic finishRun();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected completion");
      finishRun();
    end
  end

  initial begin
    tick(3);
    rstN = 1'b1;
    tick(1);
    // R1 reset state
    expectOut("R1 drive", S_DRIVE, 0);
    expectOut("R1 ready", S_READY, 0);
    expectOut("R1 error", S_ERROR, 0);
    expectOut("R1 cmd",   S_CMD,   0);
    expectOut("R1 byte",  S_BYTE,  0);
    expectOut("R1 perr",  S_PERR,  0);
    expectOut("R1 prdy",  S_PRDY,  1);

    // R2 drive write
    rdrCtlWr = 1; wrData = 8'h04;
    tick(1);
    rdrCtlWr = 0;
    expectOut("R2 drive set", S_DRIVE, 1);
    rdrCtlWr = 1; wrData = 8'hFB;
    tick(1);
    rdrCtlWr = 0;
    expectOut("R2 bit2 clear keeps drive", S_DRIVE, 1);

    // R3/R4 normal read cycle
    rdrDav = 1;
    tick(1);
    rdrDav = 0;
    expectOut("R3 drive cleared", S_DRIVE, 0);
    expectOut("R4 not ready yet", S_READY, 0);
    tick(SETTLE - 1);
    expectOut("R4 ready one cycle early", S_READY, 0);
    tick(1);
    expectOut("R4 ready at delay end", S_READY, 1);
    expectOut("R4 no error", S_ERROR, 0);

    // R7 read clears ready
    rdrDataRd = 1;
    tick(1);
    rdrDataRd = 0;
    expectOut("R7 ready cleared", S_READY, 0);

    // R6 second rise during delay ignored
    rdrDav = 1;
    tick(1);                       // n1
    rdrDav = 0;
    expectOut("R6 drive cleared by first rise", S_DRIVE, 0);
    tick(1);                       // n2
    rdrCtlWr = 1; wrData = 8'h04;
    tick(1);                       // n3
    rdrCtlWr = 0;
    expectOut("R6 drive set during delay", S_DRIVE, 1);
    rdrDav = 1;
    tick(1);                       // n4
    rdrDav = 0;
    expectOut("R6 drive kept on ignored rise", S_DRIVE, 1);
    tick(SETTLE - 4);              // nN
    expectOut("R6 ready not early", S_READY, 0);
    tick(1);
    expectOut("R6 ready at original time", S_READY, 1);
    rdrDataRd = 1;
    tick(1);
    rdrDataRd = 0;

    // R4 run dropped during delay: no ready
    rdrDav = 1;
    tick(1);
    rdrDav = 0;
    tick(5);
    rdrRun = 0;
    tick(SETTLE);
    expectOut("R4 no ready when run dropped", S_READY, 0);
    expectOut("R5 no error when ok at arrival", S_ERROR, 0);
    rdrRun = 1;
    tick(2);

    // R5 unpowered arrival
    rdrPower = 0;
    rdrDav = 1;
    tick(1);
    rdrDav = 0;
    expectOut("R5 error set", S_ERROR, 1);
    tick(SETTLE + 1);
    expectOut("R5 no ready", S_READY, 0);
    rdrPower = 1;
    rdrDataRd = 1;
    tick(1);
    rdrDataRd = 0;
    expectOut("R7 error cleared", S_ERROR, 0);

    // R8/R9/R11 punch
    punWr = 1; wrData = 8'hA5;
    tick(1);
    punWr = 0;
    expectOut("R8 byte latched", S_BYTE, 8'hA5);
    expectOut("R9 no pulse during write", S_CMD, 0);
    tick(1);                       // m1
    expectOut("R9 pulse started", S_CMD, 1);
    expectOut("R11 not ready in pulse", S_PRDY, 0);
    punWr = 1; wrData = 8'h3C;
    tick(1);                       // m2
    punWr = 0;
    expectOut("R8 byte held during pulse", S_BYTE, 8'hA5);
    tick(PULSE - 2);               // mP
    expectOut("R9 pulse last cycle", S_CMD, 1);
    tick(1);
    expectOut("R9 pulse ended", S_CMD, 0);
    expectOut("R11 ready after pulse", S_PRDY, 1);
    tick(3);
    expectOut("R9 no retrigger", S_CMD, 0);

    // R10/R11 punch error
    punTapeLow = 1;
    tick(1);
    expectOut("R10 tape low", S_PERR, 1);
    expectOut("R11 not ready on error", S_PRDY, 0);
    punTapeLow = 0; punSysReady = 0;
    tick(1);
    expectOut("R10 system not ready", S_PERR, 1);
    punSysReady = 1;
    tick(1);
    expectOut("R10 clear", S_PERR, 0);
    punTapeErr = 1;
    tick(1);
    expectOut("R10 chad error", S_PERR, 1);
    punTapeErr = 0;
    tick(2);
    done = 1;
    finishRun();
  end

endmodule